// File: doc/BRIEF.md
# SD Command Path Controller

This unit handles the command line of an SD host controller. When software writes a command word and a 32-bit argument, the unit builds a 48-bit command token and shifts it out on the CMD line. It sends one bit for each card-clock enable tick. Once the token is out, it listens for the card's reply. The reply is a 48-bit or a 136-bit frame, or there is none at all. The unit checks the reply's CRC7, end bit and echoed index, and each check can be switched off. The reply payload is stored in four 32-bit response registers.

The outcome goes into a small interrupt status word that software clears by writing ones. The unit raises a command-busy flag from launch until the reply is received. It raises a data-busy flag for commands that use the data lines or expect a busy reply, and holds it until DAT0 is released. The card clock is generated elsewhere and arrives only as a one-cycle enable. A self-clearing soft-reset request abandons the command phase at any point.

Top module: `sdcmd_unit`

## Requirements
- R1: An accepted command is sent as 48 bits, MSB first, one bit per `sdclk_en` tick, with `cmd_oe` high: start bit 0, direction bit 1, index = command word bits 29:24, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero seed) over the first 40 bits, then end bit 1.
- R2: A `cmd_wr` seen while both busy flags are low is accepted, and `cmd_inhibit` (status bit 0) is high from the next cycle. A `cmd_wr` seen while either flag is high is ignored.
- R3: Command word bits 17:16 select the reply: 0 none, 1 a 136-bit reply, 2 a 48-bit reply, 3 a 48-bit reply followed by busy. With no reply, bit 0 (done) of `int_status` is set and `cmd_inhibit` drops on the tick that sends the end bit.
- R4: When a 48-bit reply ends, reply bits 39:8 (the card status) are stored in `resp0`.
- R5: When a 136-bit reply ends, reply bits 127:8 are stored with the CRC byte dropped: `resp0` = bits 39:8, `resp1` = 71:40, `resp2` = 103:72, `resp3` = {8'h00, bits 127:104}.
- R6: With command word bit 19 set, a CRC7 mismatch sets `int_status` bit 17 instead of bit 0. The CRC covers reply bits 47:8 of a 48-bit reply and bits 127:8 of a 136-bit reply. With bit 19 clear, the CRC is not checked.
- R7: With command word bit 20 set, a 48-bit reply whose bits 45:40 differ from the command index sets `int_status` bit 19 instead of bit 0. With bit 20 clear, the index is not checked.
- R8: A reply whose last bit is 0 sets `int_status` bit 18 instead of bit 0.
- R9: If no start bit is sampled within 64 ticks after the end bit of the token, `int_status` bit 16 is set on the 64th tick, and both busy flags drop.
- R10: A command with data present (bit 21) or a busy reply (type 3) holds `dat_inhibit` (status bit 1) from launch until the first tick after the reply on which `dat0_in` is high.
- R11: A cycle with `int_wr` clears every `int_status` bit written as 1 and leaves the other bits unchanged.
- R12: A `srst_cmd` pulse raises `cmd_rst_busy` for one cycle. In the next cycle the command phase is abandoned: `cmd_inhibit` and `cmd_oe` drop, no status bit is set, and `cmd_rst_busy` clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdclk_en | input | 1 | One-cycle card-clock tick |
| cmd_wr | input | 1 | Command launch request |
| cmd_word | input | 32 | Command and transfer-mode word |
| cmd_arg | input | 32 | Command argument |
| srst_cmd | input | 1 | Command-path soft reset request |
| int_wr | input | 1 | Interrupt status write strobe |
| int_wdata | input | 32 | Write-one-to-clear mask |
| cmd_in | input | 1 | CMD line as sampled from the card |
| dat0_in | input | 1 | DAT0 line level |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_inhibit | output | 1 | Command busy flag |
| dat_inhibit | output | 1 | Data-line busy flag |
| cmd_rst_busy | output | 1 | Soft reset pending, self-clearing |
| int_status | output | 32 | Interrupt status word |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |

## Verification
`cmd_inhibit` and `dat_inhibit` rise one clock after an accepted launch. Each token bit appears on the tick edge that sends it. Reply outcomes land together in the status word and response registers on the tick edge that samples the reply's end bit. The timeout bit lands on the 64th quiet tick, and the soft reset acts two edges after its request. The bench runs from one thread, drives inputs on falling edges, and waits for the tick edge a result depends on before it reads at the following falling edge. The timeout check samples both one tick before and at the deadline.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int TOKEN_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int HDR_BITS   = 40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_BUSY
    } cmd_state_e;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'd0,
        RSP_LONG       = 2'd1,
        RSP_SHORT      = 2'd2,
        RSP_SHORT_BUSY = 2'd3
    } rsp_kind_e;

    // event vector, one bit per status flag
    typedef struct packed {
        logic idx_err;
        logic end_err;
        logic crc_err;
        logic timeout;
        logic done;
    } cmd_evt_t;

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_hdr(input logic [HDR_BITS-1:0] h);
        logic [6:0] c;
        c = '0;
        for (int i = HDR_BITS - 1; i >= 0; i--) begin
            c = crc7_step(c, h[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       bit_in,
    output logic [6:0] crc
);
    import sdcmd_pkg::*;

    logic [6:0] crc_d, crc_q;

    always_comb begin
        crc_d = clr ? 7'h00 : crc_q;
        if (en) begin
            crc_d = crc7_step(crc_d, bit_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdcmd_resp_store.sv
module sdcmd_resp_store #(
    parameter int WORD_W = 32,
    parameter int SR_W   = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              bit_in,
    input  logic              commit_short,
    input  logic              commit_long,
    output logic [6:0]        f_crc,
    output logic [5:0]        f_idx,
    output logic              f_end,
    output logic [WORD_W-1:0] r0,
    output logic [WORD_W-1:0] r1,
    output logic [WORD_W-1:0] r2,
    output logic [WORD_W-1:0] r3
);
    localparam int FRAME_W = SR_W + 1;

    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic [WORD_W-1:0] r0;
        logic [WORD_W-1:0] r1;
        logic [WORD_W-1:0] r2;
        logic [WORD_W-1:0] r3;
    } store_t;

    store_t d, q;
    logic [FRAME_W-1:0] frame;

    // frame as it stands once the bit on the line is included
    assign frame = {q.sr, bit_in};
    assign f_crc = frame[7:1];
    assign f_idx = frame[45:40];
    assign f_end = frame[0];

    always_comb begin
        d = q;
        if (shift) begin
            d.sr = frame[SR_W-1:0];
        end
        if (commit_short || commit_long) begin
            d.r0 = frame[39:8];
        end
        if (commit_long) begin
            d.r1 = frame[71:40];
            d.r2 = frame[103:72];
            d.r3 = {8'h00, frame[127:104]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign r0 = q.r0;
    assign r1 = q.r1;
    assign r2 = q.r2;
    assign r3 = q.r3;
endmodule

// File: rtl/sdcmd_irq.sv
module sdcmd_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // a new event outranks a clear in the same cycle
        always_comb begin
            flags_d[i] = flags_q[i];
            if (clr_wr && clr_mask[i]) flags_d[i] = 1'b0;
            if (set[i])                flags_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/sdcmd_unit.sv
module sdcmd_unit #(
    parameter int TIMEOUT_TICKS = 64,
    parameter int WORD_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdclk_en,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_word,
    input  logic [31:0]       cmd_arg,
    input  logic              srst_cmd,
    input  logic              int_wr,
    input  logic [31:0]       int_wdata,
    input  logic              cmd_in,
    input  logic              dat0_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              cmd_inhibit,
    output logic              dat_inhibit,
    output logic              cmd_rst_busy,
    output logic [31:0]       int_status,
    output logic [WORD_W-1:0] resp0,
    output logic [WORD_W-1:0] resp1,
    output logic [WORD_W-1:0] resp2,
    output logic [WORD_W-1:0] resp3
);
    import sdcmd_pkg::*;

    localparam int TMR_W   = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam int CNT_W   = $clog2(LONG_BITS);
    localparam int N_EVT   = $bits(cmd_evt_t);
    localparam int LONG_LO = 8;
    localparam int LONG_HI = LONG_BITS - 8;

    typedef struct packed {
        cmd_state_e           st;
        logic [TOKEN_BITS-1:0] tx_sr;
        logic [CNT_W-1:0]     cnt;
        logic [TMR_W-1:0]     tmr;
        rsp_kind_e            rsp;
        logic                 crc_chk;
        logic                 idx_chk;
        logic [5:0]           idx;
        logic                 dat_hold;
        logic                 cmd_inh;
        logic                 dat_inh;
        logic                 oe;
        logic                 out;
        logic                 rst_pend;
    } ctl_t;

    ctl_t     d, q;
    cmd_evt_t evt;
    logic     crc_clr, crc_en, rx_shift, commit_short, commit_long;
    logic [6:0] rx_crc, f_crc;
    logic [5:0] f_idx;
    logic       f_end;
    logic       last_rx;
    logic       bad_crc, bad_idx, bad_end;
    logic [39:0] hdr;
    logic [N_EVT-1:0] irq_flags;
    logic unused_bits;

    assign unused_bits = ^{cmd_word[31:30], cmd_word[23:22], cmd_word[18], cmd_word[15:0],
                           int_wdata[31:20], int_wdata[15:1]};

    assign hdr = {1'b0, 1'b1, cmd_word[29:24], cmd_arg};

    always_comb begin
        d            = q;
        evt          = '0;
        crc_clr      = 1'b0;
        crc_en       = 1'b0;
        rx_shift     = 1'b0;
        commit_short = 1'b0;
        commit_long  = 1'b0;
        last_rx      = (q.rsp == RSP_LONG) ? (q.cnt == CNT_W'(LONG_BITS - 1))
                                           : (q.cnt == CNT_W'(TOKEN_BITS - 1));
        bad_end      = !f_end;
        bad_crc      = q.crc_chk && (rx_crc != f_crc);
        bad_idx      = q.idx_chk && (q.rsp != RSP_LONG) && (f_idx != q.idx);

        // release the line one tick after the last driven bit
        if (sdclk_en && q.st != ST_SEND) begin
            d.oe  = 1'b0;
            d.out = 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    d.tx_sr    = {hdr, crc7_hdr(hdr), 1'b1};
                    d.cnt      = '0;
                    d.rsp      = rsp_kind_e'(cmd_word[17:16]);
                    d.crc_chk  = cmd_word[19];
                    d.idx_chk  = cmd_word[20];
                    d.idx      = cmd_word[29:24];
                    d.dat_hold = cmd_word[21] || (cmd_word[17:16] == 2'd3);
                    d.cmd_inh  = 1'b1;
                    d.dat_inh  = d.dat_hold;
                    d.st       = ST_SEND;
                end
            end
            ST_SEND: begin
                if (sdclk_en) begin
                    d.oe    = 1'b1;
                    d.out   = q.tx_sr[TOKEN_BITS-1];
                    d.tx_sr = {q.tx_sr[TOKEN_BITS-2:0], 1'b0};
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(TOKEN_BITS - 1)) begin
                        d.cnt = '0;
                        d.tmr = '0;
                        if (q.rsp == RSP_NONE) begin
                            evt.done  = 1'b1;
                            d.cmd_inh = 1'b0;
                            d.dat_inh = q.dat_hold;
                            d.st      = q.dat_hold ? ST_BUSY : ST_IDLE;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (sdclk_en) begin
                    if (!cmd_in) begin
                        crc_clr  = 1'b1;
                        crc_en   = (q.rsp != RSP_LONG);
                        rx_shift = 1'b1;
                        d.cnt    = CNT_W'(1);
                        d.st     = ST_RECV;
                    end else if (q.tmr == TMR_W'(TIMEOUT_TICKS - 1)) begin
                        evt.timeout = 1'b1;
                        d.cmd_inh   = 1'b0;
                        d.dat_inh   = 1'b0;
                        d.st        = ST_IDLE;
                    end else begin
                        d.tmr = q.tmr + 1'b1;
                    end
                end
            end
            ST_RECV: begin
                if (sdclk_en) begin
                    rx_shift = 1'b1;
                    crc_en   = (q.rsp == RSP_LONG)
                             ? (q.cnt >= CNT_W'(LONG_LO) && q.cnt < CNT_W'(LONG_HI))
                             : (q.cnt < CNT_W'(HDR_BITS));
                    d.cnt    = q.cnt + 1'b1;
                    if (last_rx) begin
                        commit_long  = (q.rsp == RSP_LONG);
                        commit_short = (q.rsp != RSP_LONG);
                        evt.crc_err  = bad_crc;
                        evt.idx_err  = bad_idx;
                        evt.end_err  = bad_end;
                        evt.done     = !(bad_crc || bad_idx || bad_end);
                        d.cnt        = '0;
                        d.cmd_inh    = 1'b0;
                        d.dat_inh    = q.dat_hold;
                        d.st         = q.dat_hold ? ST_BUSY : ST_IDLE;
                    end
                end
            end
            ST_BUSY: begin
                if (sdclk_en && dat0_in) begin
                    d.dat_inh = 1'b0;
                    d.st      = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // pending soft reset overrides the command phase
        d.rst_pend = srst_cmd;
        if (q.rst_pend) begin
            evt          = '0;
            commit_short = 1'b0;
            commit_long  = 1'b0;
            rx_shift     = 1'b0;
            crc_en       = 1'b0;
            d.cmd_inh    = 1'b0;
            d.dat_inh    = q.dat_inh;
            d.oe         = 1'b0;
            d.out        = 1'b1;
            d.cnt        = '0;
            d.st         = q.dat_inh ? ST_BUSY : ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.rsp <= RSP_NONE;
            q.out <= 1'b1;
        end else begin
            q <= d;
        end
    end

    sdcmd_crc7 u_rx_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .en     (crc_en),
        .bit_in (cmd_in),
        .crc    (rx_crc)
    );

    sdcmd_resp_store #(.WORD_W(WORD_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift        (rx_shift),
        .bit_in       (cmd_in),
        .commit_short (commit_short),
        .commit_long  (commit_long),
        .f_crc        (f_crc),
        .f_idx        (f_idx),
        .f_end        (f_end),
        .r0           (resp0),
        .r1           (resp1),
        .r2           (resp2),
        .r3           (resp3)
    );

    sdcmd_irq #(.N(N_EVT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (evt),
        .clr_wr   (int_wr),
        .clr_mask ({int_wdata[19], int_wdata[18], int_wdata[17], int_wdata[16], int_wdata[0]}),
        .flags    (irq_flags)
    );

    always_comb begin
        int_status     = '0;
        int_status[0]  = irq_flags[0];
        int_status[16] = irq_flags[1];
        int_status[17] = irq_flags[2];
        int_status[18] = irq_flags[3];
        int_status[19] = irq_flags[4];
    end

    assign cmd_out      = q.out;
    assign cmd_oe       = q.oe;
    assign cmd_inhibit  = q.cmd_inh;
    assign dat_inhibit  = q.dat_inh;
    assign cmd_rst_busy = q.rst_pend;
endmodule

// File: rtl/sdcmd_unit_chk.sv
module sdcmd_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [31:0] cmd_word,
    input logic        srst_cmd,
    input logic        int_wr,
    input logic [31:0] int_wdata,
    input logic        cmd_oe,
    input logic        cmd_inhibit,
    input logic        dat_inhibit,
    input logic        cmd_rst_busy,
    input logic [31:0] int_status,
    input logic [31:0] resp0
);
    logic accept;
    assign accept = cmd_wr && !cmd_inhibit && !dat_inhibit && !cmd_rst_busy;

    p_launch_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cmd_inhibit);

    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_word[21] || cmd_word[17:16] == 2'd3)) |=> dat_inhibit);

    p_drive_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> cmd_inhibit);

    p_done_frees_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[0]) |-> !cmd_inhibit);

    p_timeout_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[16]) |-> (!cmd_inhibit && !dat_inhibit));

    p_w1c_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_status[0]) |-> $past(int_wr && int_wdata[0]));

    p_w1c_timeout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_status[16]) |-> $past(int_wr && int_wdata[16]));

    p_rst_selfclear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rst_busy && !srst_cmd) |=> (!cmd_rst_busy && !cmd_inhibit && !cmd_oe));

    p_resp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_inhibit) |-> $stable(resp0));
endmodule

bind sdcmd_unit sdcmd_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_word     (cmd_word),
    .srst_cmd     (srst_cmd),
    .int_wr       (int_wr),
    .int_wdata    (int_wdata),
    .cmd_oe       (cmd_oe),
    .cmd_inhibit  (cmd_inhibit),
    .dat_inhibit  (dat_inhibit),
    .cmd_rst_busy (cmd_rst_busy),
    .int_status   (int_status),
    .resp0        (resp0)
);

// File: tb/sdcmd_unit_bench.sv
`timescale 1ns/1ps
module sdcmd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdclk_en = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] cmd_arg = '0;
    logic        srst_cmd = 1'b0;
    logic        int_wr = 1'b0;
    logic [31:0] int_wdata = '0;
    logic        cmd_in = 1'b1;
    logic        dat0_in = 1'b1;
    logic        cmd_out, cmd_oe, cmd_inhibit, dat_inhibit, cmd_rst_busy;
    logic [31:0] int_status, resp0, resp1, resp2, resp3;

    int checks = 0;
    int errs = 0;
    logic [7:0] div = '0;
    logic last_tick = 1'b0;

    always #2.5 clk = ~clk;

    sdcmd_unit u_sdcmd_unit (
        .clk(clk), .rst_n(rst_n), .sdclk_en(sdclk_en), .cmd_wr(cmd_wr),
        .cmd_word(cmd_word), .cmd_arg(cmd_arg), .srst_cmd(srst_cmd),
        .int_wr(int_wr), .int_wdata(int_wdata), .cmd_in(cmd_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_inhibit(cmd_inhibit),
        .dat_inhibit(dat_inhibit), .cmd_rst_busy(cmd_rst_busy),
        .int_status(int_status), .resp0(resp0), .resp1(resp1),
        .resp2(resp2), .resp3(resp3)
    );

    localparam logic [31:0] K_SHORT = 32'h0002_0000;
    localparam logic [31:0] K_LONG  = 32'h0001_0000;
    localparam logic [31:0] K_BUSY  = 32'h0003_0000;
    localparam logic [31:0] K_CRC   = 32'h0008_0000;
    localparam logic [31:0] K_IDX   = 32'h0010_0000;
    localparam logic [31:0] K_DATA  = 32'h0020_0000;

    // fault: 0 clean, 1 bad crc, 2 wrong index, 3 end bit low
    typedef struct packed {
        logic [31:0] word;
        logic [31:0] arg;
        logic [1:0]  fault;
        logic [31:0] exp_int;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{(32'd13 << 24) | K_SHORT | K_CRC | K_IDX, 32'h1234_0000, 2'd0, 32'h0000_0001},
        '{(32'd2  << 24) | K_LONG  | K_CRC,         32'hCAFE_F00D, 2'd0, 32'h0000_0001},
        '{(32'd8  << 24) | K_SHORT | K_CRC | K_IDX, 32'h0000_01AA, 2'd1, 32'h0002_0000},
        '{(32'd7  << 24) | K_SHORT | K_CRC | K_IDX, 32'h5555_0000, 2'd2, 32'h0008_0000},
        '{(32'd16 << 24) | K_SHORT,                 32'h0000_0200, 2'd2, 32'h0000_0001},
        '{(32'd55 << 24) | K_SHORT | K_CRC | K_IDX, 32'hABCD_0000, 2'd3, 32'h0004_0000},
        '{(32'd9  << 24) | K_LONG  | K_CRC,         32'h8765_4321, 2'd1, 32'h0002_0000},
        '{(32'd41 << 24) | K_SHORT,                 32'h40FF_8000, 2'd1, 32'h0000_0001}
    };

    function automatic logic [6:0] crc_n(input logic [127:0] v, input int n);
        logic [6:0] c = '0;
        logic fb;
        for (int i = n - 1; i >= 0; i--) begin
            fb = v[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'b000_1001;
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        last_tick = sdclk_en;
        div = div + 8'd1;
        sdclk_en = (div[1:0] == 2'b00);
    endtask

    task automatic tick();
        do cycle(); while (!last_tick);
    endtask

    task automatic launch(input logic [31:0] w, input logic [31:0] a);
        cmd_word = w;
        cmd_arg  = a;
        cmd_wr   = 1'b1;
        cycle();
        cmd_wr   = 1'b0;
    endtask

    task automatic capture(output logic [47:0] tok, output int n);
        tok = '0;
        n = 0;
        for (int g = 0; g < 400 && n < 48; g++) begin
            tick();
            if (cmd_oe) begin
                tok = {tok[46:0], cmd_out};
                n++;
            end
        end
    endtask

    task automatic send(input logic [135:0] f, input int len);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_in = f[i];
            tick();
        end
        cmd_in = 1'b1;
    endtask

    task automatic clear_int(input logic [31:0] m);
        int_wdata = m;
        int_wr = 1'b1;
        cycle();
        int_wr = 1'b0;
    endtask

    function automatic logic [47:0] exp_token(input logic [31:0] w, input logic [31:0] a);
        logic [39:0] h;
        h = {2'b01, w[29:24], a};
        return {h, crc_n({88'h0, h}, 40), 1'b1};
    endfunction

    initial begin : main
        logic [47:0]  tok;
        int           n;
        logic [135:0] fr;
        logic [119:0] body;
        logic [31:0]  stat;
        logic [5:0]   ridx;
        logic [6:0]   c;

        repeat (4) cycle();
        rst_n = 1'b1;
        cycle();

        // reset state
        chk(int_status == 0 && resp0 == 0 && resp3 == 0, "R2 reset status/resp", {int_status, resp0}, 64'h0);
        chk(!cmd_inhibit && !dat_inhibit && !cmd_oe && cmd_out && !cmd_rst_busy,
            "R2 reset flags", {cmd_inhibit, dat_inhibit, cmd_oe, cmd_out, cmd_rst_busy}, 5'b00010);

        // known token for index 0, argument 0, no reply; second request while busy is ignored
        launch(32'h0, 32'h0);
        chk(cmd_inhibit, "R2 inhibit after launch", cmd_inhibit, 1);
        launch((32'd9 << 24) | K_SHORT, 32'hFFFF_FFFF);
        capture(tok, n);
        chk(n == 48 && tok == 48'h4000_0000_0095, "R1 R2 token idx0", tok, 48'h4000_0000_0095);
        chk(int_status == 32'h1 && !cmd_inhibit, "R3 no-reply done", {int_status, 31'b0, cmd_inhibit}, {32'h1, 32'h0});
        clear_int(32'h1);

        // table of reply cases
        for (int v = 0; v < NV; v++) begin
            launch(VECS[v].word, VECS[v].arg);
            capture(tok, n);
            chk(n == 48 && tok == exp_token(VECS[v].word, VECS[v].arg), "R1 token", tok,
                exp_token(VECS[v].word, VECS[v].arg));
            repeat (v + 1) tick();
            if (VECS[v].word[17:16] == 2'd1) begin
                body = {VECS[v].arg, ~VECS[v].arg, VECS[v].arg ^ 32'hA5A5_A5A5, VECS[v].arg[23:0]};
                c = crc_n({8'h0, body}, 120);
                if (VECS[v].fault == 2'd1) c = c ^ 7'h01;
                fr = {2'b00, 6'h3F, body, c, VECS[v].fault != 2'd3};
                send(fr, 136);
                chk(resp0 == body[31:0] && resp1 == body[63:32], "R5 long low words",
                    {resp1, resp0}, {body[63:32], body[31:0]});
                chk(resp2 == body[95:64] && resp3 == {8'h00, body[119:96]}, "R5 long high words",
                    {resp3, resp2}, {8'h00, body[119:96], body[95:64]});
            end else begin
                stat = VECS[v].arg ^ 32'hC0DE_0000;
                ridx = VECS[v].word[29:24] + ((VECS[v].fault == 2'd2) ? 6'd1 : 6'd0);
                c = crc_n({88'h0, 2'b00, ridx, stat}, 40);
                if (VECS[v].fault == 2'd1) c = c ^ 7'h01;
                fr = {88'h0, 2'b00, ridx, stat, c, VECS[v].fault != 2'd3};
                send(fr, 48);
                chk(resp0 == stat, "R4 short status", resp0, stat);
            end
            case (VECS[v].fault)
                2'd1:    chk(int_status == VECS[v].exp_int, "R6 crc outcome", int_status, VECS[v].exp_int);
                2'd2:    chk(int_status == VECS[v].exp_int, "R7 index outcome", int_status, VECS[v].exp_int);
                2'd3:    chk(int_status == VECS[v].exp_int, "R8 end bit outcome", int_status, VECS[v].exp_int);
                default: chk(int_status == VECS[v].exp_int, "R3 clean reply", int_status, VECS[v].exp_int);
            endcase
            chk(!cmd_inhibit && !dat_inhibit, "R2 flags after reply", {cmd_inhibit, dat_inhibit}, 2'b00);
            if (VECS[v].exp_int != 32'h1) begin
                clear_int(32'h1);
                chk(int_status == VECS[v].exp_int, "R11 unwritten bit kept", int_status, VECS[v].exp_int);
            end
            clear_int(VECS[v].exp_int);
            chk(int_status == 0, "R11 written bit cleared", int_status, 0);
        end

        // reply timeout
        launch((32'd13 << 24) | K_SHORT | K_CRC, 32'h0);
        capture(tok, n);
        repeat (63) tick();
        chk(int_status[16] == 1'b0 && cmd_inhibit, "R9 not yet at tick 63", {int_status[16], cmd_inhibit}, 2'b01);
        tick();
        chk(int_status == 32'h0001_0000 && !cmd_inhibit && !dat_inhibit, "R9 timeout at tick 64",
            int_status, 32'h0001_0000);
        clear_int(32'h0001_0000);

        // busy reply holds data flag until DAT0 goes high
        launch((32'd7 << 24) | K_BUSY | K_CRC | K_IDX, 32'h0001_0000);
        cycle();
        chk(dat_inhibit && cmd_inhibit, "R10 busy flags at launch", {dat_inhibit, cmd_inhibit}, 2'b11);
        capture(tok, n);
        dat0_in = 1'b0;
        c = crc_n({88'h0, 2'b00, 6'd7, 32'h0000_0700}, 40);
        send({88'h0, 2'b00, 6'd7, 32'h0000_0700, c, 1'b1}, 48);
        repeat (3) tick();
        chk(dat_inhibit && !cmd_inhibit && int_status == 32'h1, "R10 held while DAT0 low",
            {dat_inhibit, cmd_inhibit, int_status}, {1'b1, 1'b0, 32'h1});
        launch((32'd13 << 24) | K_SHORT, 32'h0);
        tick();
        chk(!cmd_oe && !cmd_inhibit, "R2 launch ignored while data busy", {cmd_oe, cmd_inhibit}, 2'b00);
        dat0_in = 1'b1;
        tick();
        chk(!dat_inhibit, "R10 released on DAT0 high", dat_inhibit, 0);
        clear_int(32'h1);

        // data-present command without busy reply
        launch((32'd17 << 24) | K_SHORT | K_DATA, 32'h0000_0400);
        capture(tok, n);
        dat0_in = 1'b0;
        c = crc_n({88'h0, 2'b00, 6'd17, 32'h0000_0900}, 40);
        send({88'h0, 2'b00, 6'd17, 32'h0000_0900, c, 1'b1}, 48);
        chk(dat_inhibit && !cmd_inhibit, "R10 data command holds", {dat_inhibit, cmd_inhibit}, 2'b10);
        dat0_in = 1'b1;
        tick();
        chk(!dat_inhibit, "R10 data command release", dat_inhibit, 0);
        clear_int(32'h1);

        // soft reset during token transmission
        launch((32'd13 << 24) | K_SHORT, 32'h0);
        repeat (10) tick();
        srst_cmd = 1'b1;
        cycle();
        srst_cmd = 1'b0;
        chk(cmd_rst_busy && cmd_inhibit, "R12 request seen", {cmd_rst_busy, cmd_inhibit}, 2'b11);
        cycle();
        chk(!cmd_rst_busy && !cmd_inhibit && !cmd_oe, "R12 self-clear and abort",
            {cmd_rst_busy, cmd_inhibit, cmd_oe}, 3'b000);
        repeat (60) tick();
        chk(int_status == 0, "R12 no status after abort", int_status, 0);
        launch(32'h0, 32'h0);
        capture(tok, n);
        chk(tok == 48'h4000_0000_0095 && int_status == 32'h1, "R12 R1 usable after reset",
            tok, 48'h4000_0000_0095);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule